// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Readout

This block is the digital core of a 12-bit successive-approximation converter that is read over a three-wire serial link. An active-low select input both starts a conversion and, while held high, keeps the block powered down. An externally supplied data clock paces the whole sequence. The block drives a trial code toward the analog comparison network and reads back a single comparator decision bit. It runs an acquisition window and twelve binary-search decisions. Each decided bit is shifted out on a serial data line with an output-enable, so a board-level tri-state buffer can share the line.

Each result bit appears on the serial line at the data-clock falling edge right after it has been decided, so the word has no pipeline latency. A single low null bit comes before the word. After the most-significant-first word, the block plays the same word back least-significant-first, without repeating the lowest bit. It then either releases the line or holds it at zero, depending on a parameter. A host that needs only a few leading bits can raise select early. This aborts the conversion and returns the block to power-down.

All inputs are synchronous to the system clock `clk`. The block detects data-clock edges by comparing each input sample with the sample taken one system clock earlier. Every output change takes effect on the first `clk` rising edge that sees the edge causing it.

Top module: `sar_serial_seq`

## Requirements
- R1: While `selN` is high the block is powered down: `sdoOe` is 0 from the next `clk` cycle onward, and data-clock activity does not enable it.
- R2: A conversion starts only on a high-to-low transition of `selN`. If `selN` is held low out of reset, or after a finished conversion, no new output is driven.
- R3: After a start, the first data-clock falling edge belongs to acquisition, and `sdoOe` stays 0.
- R4: On the second data-clock falling edge after the start, `sdoOe` becomes 1 and `sdo` drives a null bit of value 0.
- R5: On each of the next 12 falling edges, `sdo` presents one result bit, B11 first and B0 last, in straight binary. With a comparator that answers 1 when the trial code is at or below the target, the word equals the target, including 000h and FFFh.
- R6: When the null bit is driven, `trialCode` is 800h. Each decision takes `cmpIn` as sampled at the data-clock rising edge before the bit is presented. A 1 keeps the bit under test and a 0 clears it, and the next lower bit is then set for trial. After the last decision, `trialCode` holds the result.
- R7: On the 11 falling edges after B0, `sdo` presents B1, B2, … B11, so B0 is not repeated.
- R8: After the replayed B11, with `ZERO_TAIL`=0 the next falling edge drops `sdoOe` to 0. With `ZERO_TAIL`=1, `sdoOe` stays 1 with `sdo` at 0. Further data clocks change nothing.
- R9: Raising `selN` at any point in the sequence aborts it within one `clk` cycle. A following high-to-low transition starts a fresh, correct conversion.
- R10: During and right after reset, `sdoOe`, `sdo` and `trialCode` are all 0.
- R11: While `selN` stays low, `sdo` and `sdoOe` change only in a `clk` cycle that sees a data-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Active-low select; high means power-down |
| dataClk | input | 1 | External data clock, sampled on `clk` |
| cmpIn | input | 1 | Comparator decision for the current trial code |
| trialCode | output | WIDTH | Trial code presented to the analog network |
| sdo | output | 1 | Serial data bit |
| sdoOe | output | 1 | Serial output enable (0 = high impedance) |

## Verification
A wrong state or bit counter shows up as a misplaced null bit, or as a word shifted by one position. This is visible at the first falling edge where the serial line departs from the expected frame, at most 27 data clocks after the start. A wrong decision index corrupts `trialCode` at the next rising edge and shows up in the word as a wrong bit at that bit's own falling edge. A stale abort path leaves `sdoOe` high one `clk` cycle after `selN` rises. A lost end-of-sequence state shows up as output activity past the replayed top bit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Index field width carried in the strobe bundle; supports words up to 64 bits.
  localparam int IDX_MAX_W = 6;

  typedef logic [IDX_MAX_W-1:0] bitIdx_t;

  // Strobes from the sequencer control to the datapath, valid for one clk cycle.
  typedef struct packed {
    logic    clear;     // power-down: release line, drop trial code
    logic    start;     // load the first trial code (top bit set)
    logic    decide;    // resolve bit decIdx from the comparator
    bitIdx_t decIdx;
    logic    showNull;  // enable the line with a low null bit
    logic    showBit;   // present decided bit outIdx
    bitIdx_t outIdx;
    logic    showTail;  // end of frame: release or hold zero
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ACQ,
    ST_NULL,
    ST_MSB,
    ST_LSB,
    ST_DONE
  } seqState_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       dataClk,
  output seqStrobe_t strobe
);

  localparam int IDXW = $clog2(WIDTH);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  seqState_t       state, stateNext;
  logic [IDXW-1:0] bitCnt, bitCntNext;
  logic            acqSeen, acqSeenNext;
  logic            selPrev, dclkPrev;
  logic            selFall, dRise, dFall;

  assign selFall = selPrev && !selN;
  assign dRise   = !dclkPrev && dataClk;
  assign dFall   = dclkPrev && !dataClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_OFF;
      bitCnt   <= '0;
      acqSeen  <= 1'b0;
      selPrev  <= 1'b0;  // a start needs select to be seen high first
      dclkPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      bitCnt   <= bitCntNext;
      acqSeen  <= acqSeenNext;
      selPrev  <= selN;
      dclkPrev <= dataClk;
    end
  end

  always_comb begin
    stateNext   = state;
    bitCntNext  = bitCnt;
    acqSeenNext = acqSeen;
    strobe      = '0;
    if (selN) begin
      stateNext    = ST_OFF;
      strobe.clear = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (selFall) begin
            stateNext   = ST_ACQ;
            acqSeenNext = 1'b0;
          end
        end
        ST_ACQ: begin
          if (dFall) begin
            if (acqSeen) begin
              stateNext       = ST_NULL;
              strobe.start    = 1'b1;
              strobe.showNull = 1'b1;
            end else begin
              acqSeenNext = 1'b1;
            end
          end
        end
        ST_NULL: begin
          if (dRise) begin
            strobe.decide = 1'b1;
            strobe.decIdx = IDX_MAX_W'(TOP_IDX);
          end
          if (dFall) begin
            stateNext      = ST_MSB;
            bitCntNext     = TOP_IDX;
            strobe.showBit = 1'b1;
            strobe.outIdx  = IDX_MAX_W'(TOP_IDX);
          end
        end
        ST_MSB: begin
          if (dRise && bitCnt != '0) begin
            strobe.decide = 1'b1;
            strobe.decIdx = IDX_MAX_W'(bitCnt - 1'b1);
          end
          if (dFall) begin
            strobe.showBit = 1'b1;
            if (bitCnt != '0) begin
              bitCntNext    = bitCnt - 1'b1;
              strobe.outIdx = IDX_MAX_W'(bitCnt - 1'b1);
            end else begin
              stateNext     = ST_LSB;
              bitCntNext    = IDXW'(1);
              strobe.outIdx = IDX_MAX_W'(1);
            end
          end
        end
        ST_LSB: begin
          if (dFall) begin
            if (bitCnt != TOP_IDX) begin
              bitCntNext     = bitCnt + 1'b1;
              strobe.showBit = 1'b1;
              strobe.outIdx  = IDX_MAX_W'(bitCnt + 1'b1);
            end else begin
              stateNext       = ST_DONE;
              strobe.showTail = 1'b1;
            end
          end
        end
        default: ;  // ST_DONE: wait for select to rise
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter bit ZERO_TAIL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] trialCode,
  output logic             sdo,
  output logic             sdoOe
);

  localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial, trialNext;
  logic             pickBit;

  // Decision update: keep/clear the bit under test, raise the next lower one.
  always_comb begin
    trialNext = trial;
    for (int b = 0; b < WIDTH; b++) begin
      if (strobe.decIdx == IDX_MAX_W'(b))
        trialNext[b] = cmpIn;
      else if (strobe.decIdx == IDX_MAX_W'(b + 1))
        trialNext[b] = 1'b1;
    end
  end

  // Output selection of a decided bit.
  always_comb begin
    pickBit = 1'b0;
    for (int b = 0; b < WIDTH; b++) begin
      if (strobe.outIdx == IDX_MAX_W'(b)) pickBit = trial[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial <= '0;
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end else if (strobe.clear) begin
      trial <= '0;
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end else begin
      if (strobe.start)       trial <= FIRST_TRIAL;
      else if (strobe.decide) trial <= trialNext;

      if (strobe.showNull) begin
        sdo   <= 1'b0;
        sdoOe <= 1'b1;
      end else if (strobe.showBit) begin
        sdo <= pickBit;
      end else if (strobe.showTail) begin
        sdo   <= 1'b0;
        sdoOe <= ZERO_TAIL;
      end
    end
  end

  assign trialCode = trial;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter bit ZERO_TAIL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             dataClk,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] trialCode,
  output logic             sdo,
  output logic             sdoOe
);

  seqStrobe_t strobe;

  sar_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .dataClk (dataClk),
    .strobe  (strobe)
  );

  sar_seq_dp #(.WIDTH(WIDTH), .ZERO_TAIL(ZERO_TAIL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpIn     (cmpIn),
    .trialCode (trialCode),
    .sdo       (sdo),
    .sdoOe     (sdoOe)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             selN,
  input logic             dataClk,
  input logic [WIDTH-1:0] trialCode,
  input logic             sdo,
  input logic             sdoOe
);

  localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  logic dclkQ;
  logic fallNow;

  always_ff @(posedge clk) begin
    if (!rstN) dclkQ <= 1'b0;
    else       dclkQ <= dataClk;
  end

  assign fallNow = dclkQ && !dataClk;

  // R1: select high powers the line down on the next cycle
  a_r1_powerdown_release: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> !sdoOe);

  // R4: the line is enabled with a low null bit
  a_r4_null_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> !sdo);

  // R6: enabling the line coincides with the first trial code
  a_r6_first_trial: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> trialCode == FIRST_TRIAL);

  // R11: no output change without a data-clock falling edge while selected
  a_r11_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !fallNow) |=> ($stable(sdo) && $stable(sdoOe)));

endmodule

bind sar_serial_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .selN      (selN),
  .dataClk   (dataClk),
  .trialCode (trialCode),
  .sdo       (sdo),
  .sdoOe     (sdoOe)
);

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

  localparam int W      = 12;
  localparam int NCAP   = 27;
  localparam int HALF   = 4;
  localparam int NVEC   = 8;
  localparam logic [W-1:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                          12'hA5C, 12'h123, 12'h001, 12'hFFE};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b0;
  logic dataClk = 1'b0;
  logic [W-1:0] target = '0;
  logic [W-1:0] trialA, trialB;
  logic sdoA, oeA, sdoB, oeB;
  logic cmpA, cmpB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic oeCap [NCAP], sdoCap [NCAP], oeZt [NCAP], sdoZt [NCAP];
  logic midOe [NCAP], midSdo [NCAP];

  always #2 clk = ~clk;

  // Comparator model: 1 when trial code is at or below the target
  assign cmpA = (trialA <= target);
  assign cmpB = (trialB <= target);

  sar_serial_seq #(.WIDTH(W), .ZERO_TAIL(1'b0)) u_sar_serial_seq (
    .clk(clk), .rstN(rstN), .selN(selN), .dataClk(dataClk), .cmpIn(cmpA),
    .trialCode(trialA), .sdo(sdoA), .sdoOe(oeA));

  sar_serial_seq #(.WIDTH(W), .ZERO_TAIL(1'b1)) u_sar_serial_seq_zt (
    .clk(clk), .rstN(rstN), .selN(selN), .dataClk(dataClk), .cmpIn(cmpB),
    .trialCode(trialB), .sdo(sdoB), .sdoOe(oeB));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dcycle(output logic mO, output logic mS);
    dataClk = 1'b1;
    repeat (HALF) @(negedge clk);
    mO = oeA; mS = sdoA;
    dataClk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic startConv();
    selN = 1'b1;
    repeat (3) @(negedge clk);
    selN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      dcycle(midOe[i], midSdo[i]);
      oeCap[i] = oeA; sdoCap[i] = sdoA;
      oeZt[i]  = oeB; sdoZt[i]  = sdoB;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic mo, ms;
    logic [W-1:0] msbW, lsbW;
    bit oeAll, stable, tailA, tailB;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(oeA == 0 && sdoA == 0 && trialA == 0, "R10 reset outputs", {oeA, sdoA, trialA}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(oeA == 0 && sdoA == 0 && trialA == 0, "R10 after reset", {oeA, sdoA, trialA}, 0);

    // R2: select low out of reset without a high phase starts nothing
    oeAll = 0;
    for (int i = 0; i < 4; i++) begin dcycle(mo, ms); oeAll |= oeA | mo; end
    check(!oeAll, "R2 no start while held low", oeAll, 0);

    // R1: select high with clocks running keeps the line released
    selN = 1'b1;
    oeAll = 0;
    for (int i = 0; i < 4; i++) begin dcycle(mo, ms); oeAll |= oeA | mo; end
    check(!oeAll, "R1 power-down with clocks", oeAll, 0);

    // Vector table: full conversions
    for (int v = 0; v < NVEC; v++) begin
      target = VEC[v];
      startConv();
      capture(NCAP);
      msbW = '0; lsbW = '0; oeAll = 1; stable = 1;
      for (int i = 2; i <= 13; i++) begin msbW[13-i] = sdoCap[i]; oeAll &= oeCap[i]; end
      for (int i = 14; i <= 24; i++) begin lsbW[i-13] = sdoCap[i]; oeAll &= oeCap[i]; end
      for (int i = 1; i < NCAP; i++)
        stable &= (midOe[i] == oeCap[i-1]) && (midSdo[i] == sdoCap[i-1]);
      tailA = !oeCap[25] && !oeCap[26];
      tailB = oeZt[25] && oeZt[26] && !sdoZt[25] && !sdoZt[26];
      check(oeCap[0] == 0, "R3 acquisition released", oeCap[0], 0);
      check(oeCap[1] == 1 && sdoCap[1] == 0, "R4 null bit", {oeCap[1], sdoCap[1]}, 2'b10);
      check(msbW == target && oeAll, "R5 msb-first word", msbW, target);
      check(trialA == target, "R6 final trial code", trialA, target);
      check(lsbW[W-1:1] == target[W-1:1], "R7 lsb-first replay", lsbW, {target[W-1:1], 1'b0});
      check(tailA && tailB, "R8 tail release/zero", {tailA, tailB}, 2'b11);
      check(stable, "R11 changes only on falling edge", stable, 1);
    end

    // R2: after a finished frame, more clocks with select low do nothing
    oeAll = 0;
    for (int i = 0; i < 3; i++) begin dcycle(mo, ms); oeAll |= oeA; end
    check(!oeAll, "R2 no restart after frame", oeAll, 0);

    // R6: first trial code at the null bit
    target = 12'h5A3;
    startConv();
    dcycle(mo, ms);
    dcycle(mo, ms);
    check(trialA == 12'h800, "R6 first trial code", trialA, 12'h800);

    // R9: short cycle after B11..B7, then restart
    target = 12'hA5C;
    startConv();
    capture(7);
    msbW = '0;
    for (int i = 2; i <= 6; i++) msbW[13-i] = sdoCap[i];
    check(msbW[11:7] == target[11:7], "R9 leading bits before abort", msbW[11:7], target[11:7]);
    selN = 1'b1;
    @(negedge clk);
    check(oeA == 0, "R9 abort releases line", oeA, 0);
    selN = 1'b0;
    repeat (2) @(negedge clk);
    target = 12'h3C1;
    selN = 1'b1;
    repeat (2) @(negedge clk);
    selN = 1'b0;
    repeat (2) @(negedge clk);
    capture(NCAP);
    msbW = '0;
    for (int i = 2; i <= 13; i++) msbW[13-i] = sdoCap[i];
    check(msbW == target && sdoCap[1] == 0 && oeCap[1], "R9 restart word", msbW, target);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule